// File: doc/BRIEF.md
# Scan Input Corruption Guard

This block sits on the serial stimulus path between a scan-in pin and the first cell of a scan chain. While the device is shifting in test mode, it scrambles the bits that reach the chain. It does this by XORing each bit with the output of a small maximal-length LFSR that steps once per shift clock. Anyone who shifts in a chosen pattern therefore loads a pattern they cannot predict without knowing the LFSR seed and tap set. Capture cycles and functional operation see the raw scan-in bit unchanged.

A second, optional layer watches how long a shift run lasts. A saturating run counter counts shift edges. Once it reaches its ceiling, a second, shorter LFSR XORs a further set of flips onto the already scrambled bit. This layer stays on until a genuine capture occurs, meaning scan enable is sampled low on an active clock edge in test mode. A parameter removes the second layer entirely, which leaves only the first LFSR and one XOR gate.

Top module: `scan_corrupt_guard`

## Requirements
- R1: When `test_mode` is 0 or `scan_en` is 0, `chain_si` equals `scan_si` in the same cycle.
- R2: When `test_mode` and `scan_en` are both 1 and no second-layer flip is active, `chain_si` equals `scan_si` XOR the primary LFSR output bit. With default width 8 the primary state is `p`, its output bit is `p[7]`, and on each shift edge it becomes `{p[6:0], p[7]^p[5]^p[4]^p[3]}`.
- R3: The primary LFSR uses a primitive polynomial, so with `scan_si` held at 0 its flip sequence repeats after exactly 255 shift edges (2^8-1) at default width.
- R4: The run counter (default 4 bits) increments on every clock edge where `test_mode` and `scan_en` are both 1. It saturates at 15 (2^c-1), so the 16th and later consecutive shifts receive second-layer flips.
- R5: While the run counter is saturated and a shift is in progress, `chain_si` also has the secondary LFSR output bit XORed in. With default width 5 the secondary state is `q`, its output is `q[4]`, and it becomes `{q[3:0], q[4]^q[2]}` on each shift edge taken while saturated.
- R6: The run counter clears only on a clock edge with `test_mode`=1 and `scan_en`=0. A low pulse on `scan_en` that starts and ends between two edges does not clear it, and edges with `test_mode`=0 leave it unchanged.
- R7: Both LFSRs hold their state on any edge that is not a shift edge.
- R8: With the second layer disabled by parameter, `chain_si` during shifting is always `scan_si` XOR the primary output bit, however long the shift run lasts.
- R9: Synchronous active-high `rst` loads the seeds `8'hA5` (primary) and `5'h13` (secondary) and clears the run counter. The first shifted bit after reset is therefore flipped by bit 7 of `8'hA5`, which is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan/test clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | Device is in test mode |
| scan_en | input | 1 | 1 = shift, 0 = capture (in test mode) |
| scan_si | input | 1 | Raw serial stimulus from the pin |
| chain_si | output | 1 | Stimulus bit delivered to the scan chain |

## Verification
A wrong LFSR state shows at `chain_si` on the very next shift bit, since the output bit is taken directly from the state. A skipped or extra LFSR step shifts the whole flip pattern, and a comparison bit by bit against a model flags it within a handful of shifts. A run counter that clears too early, clears on a glitch, or saturates at the wrong count is visible as second-layer flips starting on the wrong shift or disappearing. This is seen by running the full and single-layer instances in parallel on the same stimulus, from the 16th shift of a run onward.

// File: rtl/scg_pkg.sv
package scg_pkg;

    typedef enum logic [1:0] {
        MODE_FUNC    = 2'd0,
        MODE_SHIFT   = 2'd1,
        MODE_CAPTURE = 2'd2
    } scg_mode_e;

    typedef struct packed {
        logic shift;
        logic capture;
    } scg_ctl_t;

    // Feedback tap mask for a Fibonacci shift-left LFSR of width w.
    // Bit (e-1) is set for each exponent e of a primitive polynomial.
    function automatic logic [31:0] tap_mask(input int w);
        logic [31:0] m;
        case (w)
            3:  m = 32'h0000_0006;
            4:  m = 32'h0000_000C;
            5:  m = 32'h0000_0014;
            6:  m = 32'h0000_0030;
            7:  m = 32'h0000_0060;
            8:  m = 32'h0000_00B8;
            9:  m = 32'h0000_0110;
            10: m = 32'h0000_0240;
            12: m = 32'h0000_0E08;
            16: m = 32'h0000_B400;
            default: m = 32'h0000_00B8;
        endcase
        return m;
    endfunction

    function automatic scg_mode_e decode_mode(input logic tm, input logic se);
        if (!tm)
            return MODE_FUNC;
        else if (se)
            return MODE_SHIFT;
        else
            return MODE_CAPTURE;
    endfunction

    function automatic scg_ctl_t mode_to_ctl(input scg_mode_e md);
        scg_ctl_t c;
        c.shift   = (md == MODE_SHIFT);
        c.capture = (md == MODE_CAPTURE);
        return c;
    endfunction

endpackage

// File: rtl/scg_lfsr.sv
module scg_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] SEED = W'(1)
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic bit_out
);
    localparam logic [W-1:0] TAPS = W'(scg_pkg::tap_mask(W));

    logic [W-1:0] state_q;
    logic         fb;

    assign fb      = ^(state_q & TAPS);
    assign bit_out = state_q[W-1];

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SEED;
        else if (adv)
            state_q <= {state_q[W-2:0], fb};
    end

    initial begin
        assert_seed_nonzero_R3: assert (SEED != '0);
    end

    // R3: a primitive-polynomial register never enters the all-zero lockup
    assert_state_live_R3: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

    // R7: no step without an advance request
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state_q));

    // R2: an advance shifts the old state up by one position
    assert_step_shift_R2: assert property (@(posedge clk) disable iff (rst)
        adv |=> state_q[W-1:1] == $past(state_q[W-2:0]));

endmodule

// File: rtl/scg_run_counter.sv
module scg_run_counter #(
    parameter int CW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic shift,
    input  logic capture,
    output logic saturated
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] count_q;

    assign saturated = (count_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (capture)
            count_q <= '0;
        else if (shift && !saturated)
            count_q <= count_q + 1'b1;
    end

    // R4: counts up by one per shift edge below the ceiling
    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        (shift && count_q != CNT_MAX) |=> count_q == $past(count_q) + 1'b1);

    // R4: stays at the ceiling while shifting continues
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (shift && count_q == CNT_MAX) |=> count_q == CNT_MAX);

    // R6: a capture edge always empties the counter
    assert_capture_clears_R6: assert property (@(posedge clk) disable iff (rst)
        capture |=> count_q == '0);

    // R6: nothing but a capture edge can bring a non-zero count back to zero
    assert_clear_only_capture_R6: assert property (@(posedge clk) disable iff (rst)
        (count_q != '0 && !capture) |=> count_q != '0);

endmodule

// File: rtl/scan_corrupt_guard.sv
module scan_corrupt_guard #(
    parameter int              PRI_W    = 8,
    parameter logic [PRI_W-1:0] PRI_SEED = 8'hA5,
    parameter bit              L2_EN    = 1'b1,
    parameter int              CNT_W    = 4,
    parameter int              SEC_W    = 5,
    parameter logic [SEC_W-1:0] SEC_SEED = 5'h13
) (
    input  logic clk,
    input  logic rst,
    input  logic test_mode,
    input  logic scan_en,
    input  logic scan_si,
    output logic chain_si
);
    import scg_pkg::*;

    scg_mode_e mode;
    scg_ctl_t  ctl;
    logic      pri_bit;
    logic      sec_flip;

    assign mode = decode_mode(test_mode, scan_en);
    assign ctl  = mode_to_ctl(mode);

    scg_lfsr #(
        .W    (PRI_W),
        .SEED (PRI_SEED)
    ) u_pri_lfsr (
        .clk     (clk),
        .rst     (rst),
        .adv     (ctl.shift),
        .bit_out (pri_bit)
    );

    generate
        if (L2_EN) begin : g_level2
            logic sat;
            logic sec_bit;

            scg_run_counter #(
                .CW (CNT_W)
            ) u_run_cnt (
                .clk       (clk),
                .rst       (rst),
                .shift     (ctl.shift),
                .capture   (ctl.capture),
                .saturated (sat)
            );

            scg_lfsr #(
                .W    (SEC_W),
                .SEED (SEC_SEED)
            ) u_sec_lfsr (
                .clk     (clk),
                .rst     (rst),
                .adv     (ctl.shift && sat),
                .bit_out (sec_bit)
            );

            assign sec_flip = ctl.shift && sat && sec_bit;
        end else begin : g_level1_only
            assign sec_flip = 1'b0;
        end
    endgenerate

    assign chain_si = scan_si ^ (ctl.shift & pri_bit) ^ sec_flip;

    // R1: no corruption outside a shift
    assert_passthrough_R1: assert property (@(posedge clk) disable iff (rst)
        !(test_mode && scan_en) |-> chain_si == scan_si);

    // R5: the second layer only acts while shifting
    assert_sec_only_shift_R5: assert property (@(posedge clk) disable iff (rst)
        sec_flip |-> (test_mode && scan_en));

    // R8: with the second layer removed, corruption is the primary bit alone
    assert_single_layer_R8: assert property (@(posedge clk) disable iff (rst)
        (!L2_EN && test_mode && scan_en) |-> chain_si == (scan_si ^ pri_bit));

endmodule

// File: tb/scan_corrupt_guard_tb.sv
module scan_corrupt_guard_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tm  = 1'b0;
    logic se  = 1'b0;
    logic si  = 1'b0;
    logic out_full;
    logic out_l1;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 1'b0;

    // bench model of the requirements
    logic [7:0] m_pri;
    logic [4:0] m_sec;
    int         m_cnt;
    logic       last_l1;
    logic       seq_bits [0:299];

    always #10 clk = ~clk;

    scan_corrupt_guard u_dut (
        .clk(clk), .rst(rst), .test_mode(tm), .scan_en(se),
        .scan_si(si), .chain_si(out_full)
    );

    scan_corrupt_guard #(.L2_EN(1'b0)) u_dut_l1 (
        .clk(clk), .rst(rst), .test_mode(tm), .scan_en(se),
        .scan_si(si), .chain_si(out_l1)
    );

    // {test_mode, scan_en, scan_in}
    localparam int NV = 32;
    localparam logic [2:0] VEC [0:NV-1] = '{
        3'b110, 3'b111, 3'b110, 3'b110, 3'b111, 3'b111, 3'b100, 3'b101,
        3'b001, 3'b010, 3'b011, 3'b110, 3'b111, 3'b110, 3'b101, 3'b110,
        3'b110, 3'b111, 3'b111, 3'b110, 3'b110, 3'b111, 3'b110, 3'b111,
        3'b110, 3'b110, 3'b111, 3'b110, 3'b111, 3'b111, 3'b110, 3'b100
    };

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_pri = 8'hA5;
        m_sec = 5'h13;
        m_cnt = 0;
    endtask

    task automatic model_edge(input logic t, input logic s);
        if (t && s) begin
            if (m_cnt == 15) m_sec = {m_sec[3:0], m_sec[4] ^ m_sec[2]};
            m_pri = {m_pri[6:0], m_pri[7] ^ m_pri[5] ^ m_pri[4] ^ m_pri[3]};
            if (m_cnt < 15) m_cnt++;
        end else if (t && !s) begin
            m_cnt = 0;
        end
    endtask

    task automatic compare(input string tag);
        logic sh;
        logic e_l1;
        logic e_full;
        sh     = tm && se;
        e_l1   = si ^ (sh & m_pri[7]);
        e_full = e_l1 ^ (sh && m_cnt == 15 && m_sec[4]);
        check(out_full, e_full, tag);
        check(out_l1, e_l1, sh ? "R8" : "R1");
        last_l1 = out_l1;
    endtask

    task automatic apply(input logic t, input logic s, input logic d, input string tag);
        @(negedge clk);
        tm = t; se = s; si = d;
        #2;
        compare(tag);
        @(posedge clk);
        model_edge(t, s);
    endtask

    function automatic string auto_tag(input logic t, input logic s);
        if (!(t && s)) return "R1";
        if (m_cnt == 15) return "R5";
        return "R2";
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tm = 1'b0; se = 1'b0; si = 1'b0;
        @(posedge clk);
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R9: first shifted bit after reset is flipped by seed bit 7 (=1)
        apply(1'b1, 1'b1, 1'b0, "R9");

        // table walk
        do_reset();
        for (int v = 0; v < NV; v++) begin
            string tg;
            tg = auto_tag(VEC[v][2], VEC[v][1]);
            apply(VEC[v][2], VEC[v][1], VEC[v][0], tg);
        end

        // R4/R5: a long shift run crosses saturation at shift 16
        do_reset();
        apply(1'b1, 1'b0, 1'b0, "R6");
        for (int k = 0; k < 40; k++) begin
            apply(1'b1, 1'b1, k[0], (k < 15) ? "R4" : "R5");
        end

        // R6: scan_en low pulse between edges does not clear the counter
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            tm = 1'b1; se = 1'b1; si = 1'b0;
            #2 se = 1'b0;
            #3 se = 1'b1;
            #2;
            compare("R6");
            @(posedge clk);
            model_edge(1'b1, 1'b1);
        end

        // R6/R7: test_mode low edges keep count and LFSR state
        for (int k = 0; k < 5; k++) apply(1'b0, k[0], k[1], "R7");
        for (int k = 0; k < 6; k++) apply(1'b1, 1'b1, 1'b1, "R6");

        // R6: a real capture edge clears it; next shifts are level-one only
        apply(1'b1, 1'b0, 1'b1, "R6");
        for (int k = 0; k < 5; k++) apply(1'b1, 1'b1, 1'b0, "R6");

        // R7: capture edges leave both LFSRs where they were
        for (int k = 0; k < 3; k++) apply(1'b1, 1'b0, 1'b0, "R7");
        apply(1'b1, 1'b1, 1'b0, "R7");

        // R3: period of the primary flip sequence is 255 shift edges
        do_reset();
        for (int k = 0; k < 263; k++) begin
            apply(1'b1, 1'b1, 1'b0, "R3");
            seq_bits[k] = last_l1;
            if (k % 10 == 9) apply(1'b1, 1'b0, 1'b0, "R3");
        end
        for (int k = 0; k < 8; k++) check(seq_bits[k + 255], seq_bits[k], "R3");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule